// File: doc/BRIEF.md
# Streaming Moving-Average Trend Decomposer

This block splits a stream of signed samples into a slow trend and a fast residual. It is the series-decomposition front end of a linear time-series predictor. A valid-qualified input accepts one sample per clock. The block keeps the most recent 64 accepted samples in a shift-register window. Every cycle it sums the whole window through an unrolled binary adder tree. The mean comes from an arithmetic right shift by the window's log2, so no divider is needed.

The adder tree has six levels. A register bank between levels three and four splits it into two shorter timing segments. The path from a captured sample to the trend output is four register stages in total, which keeps each segment short enough for a 10 ns clock.

The residual is a chosen raw sample minus the trend. That sample is either the newest one or the one at the window centre, and a parameter picks which. The sample is carried through the pipeline alongside the sum, so it lines up with the trend of its own window.

Top module: `mavg_trend_decomp`

## Requirements
- R1: A synchronous active-high reset clears the window, every pipeline register and the valid chain. After reset, `out_valid`, `out_trend` and `out_resid` are all zero.
- R2: `out_valid` stays low until 64 samples have been accepted. The first assertion belongs to the 64th accepted sample.
- R3: The window sum is carried at sample width plus 6 bits, so it never overflows. This holds when all 64 samples are the most positive value, and when they are all the most negative value.
- R4: `out_trend` is the 64-sample sum arithmetically shifted right by 6. This rounds toward minus infinity: a window of 63 zeros and one -1 gives a trend of -1.
- R5: A sample accepted on rising edge k produces `out_valid` high, together with its trend and residual, after rising edge k+3. `out_valid` is high after an edge only for such a sample.
- R6: With the residual tap set to newest (the default), `out_resid` equals the sample just accepted minus the trend of the window that ends with it. The result is signed and one bit wider than a sample.
- R7: On a cycle where `in_valid` is low, the window does not shift and no `out_valid` results. Samples already in the pipeline still complete. Trend and residual stay unchanged after the pipeline drains.
- R8: With the residual tap set to centre, `out_resid` equals the sample accepted 32 acceptances before the newest one, minus the same trend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` on this edge |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Trend and residual belong to an accepted sample |
| out_trend | output | DATA_W | Signed window mean |
| out_resid | output | DATA_W+1 | Signed aligned sample minus trend |

## Verification
A sample captured on rising edge k shows its trend, residual and valid flag after edge k+3. The bench models this with an eight-slot ring indexed by an edge counter. At each capture it computes the expected results from its own 64-entry history and files them in the slot for edge k+3. It reads the outputs on the following falling edge and compares them with that slot. Empty slots must read back with `out_valid` low. This catches an extra or missing pipeline stage, and any output produced on a gap cycle.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

    // Which aligned sample the residual is formed from
    typedef enum logic {
        RES_NEWEST = 1'b0,
        RES_CENTRE = 1'b1
    } res_tap_e;

endpackage

// File: rtl/mavg_window.sv
// Stage 1: sample window shift register plus fill tracking.
module mavg_window #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] taps,
    output logic                    taps_vld
);
    localparam int CNT_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] taps;
        logic [CNT_W-1:0]             fill;
        logic                         vld;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d     = win_q;
        win_d.vld = 1'b0;
        if (push) begin
            win_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                win_d.taps[i] = win_q.taps[i-1];
            end
            win_d.vld  = (win_q.fill == FULL_CNT);
            win_d.fill = (win_q.fill == FULL_CNT) ? win_q.fill : win_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign taps     = win_q.taps;
    assign taps_vld = win_q.vld;

endmodule

// File: rtl/mavg_tree.sv
// Combinational segment of a balanced adder tree: each level halves the
// operand count and widens the result by one bit.
module mavg_tree #(
    parameter int IN_W   = 16,
    parameter int N_IN   = 64,
    parameter int LEVELS = 3
) (
    input  logic [N_IN*IN_W-1:0]                       operands,
    output logic [(N_IN>>LEVELS)*(IN_W+LEVELS)-1:0]    sums
);
    localparam int OUT_W = IN_W + LEVELS;
    localparam int N_OUT = N_IN >> LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
        localparam int W = IN_W + l;
        localparam int N = N_IN >> l;
        logic signed [W-1:0] node [N];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
                assign node[i] = operands[i*IN_W +: IN_W];
            end
        end else begin : g_add
            for (genvar i = 0; i < N; i++) begin : g_pair
                assign node[i] = W'(g_lv[l-1].node[2*i]) + W'(g_lv[l-1].node[2*i+1]);
            end
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign sums[i*OUT_W +: OUT_W] = g_lv[LEVELS].node[i];
    end

endmodule

// File: rtl/mavg_trend_decomp.sv
module mavg_trend_decomp
    import mavg_pkg::*;
#(
    parameter int       DATA_W   = 16,
    parameter int       WIN_LOG2 = 6,
    parameter int       CUT_LVL  = 3,
    parameter res_tap_e RES_TAP  = RES_NEWEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_trend,
    output logic [DATA_W:0]   out_resid
);
    localparam int DEPTH   = 1 << WIN_LOG2;
    localparam int N_PART  = DEPTH >> CUT_LVL;
    localparam int PART_W  = DATA_W + CUT_LVL;
    localparam int SUM_W   = DATA_W + WIN_LOG2;
    localparam int RES_W   = DATA_W + 1;
    localparam int TAP_IDX = (RES_TAP == RES_CENTRE) ? DEPTH / 2 : 0;

    // stage 1: window
    logic [DEPTH*DATA_W-1:0] taps;
    logic                    taps_vld;

    mavg_window #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_window (
        .clk      (clk),
        .rst      (rst),
        .push     (in_valid),
        .din      (in_sample),
        .taps     (taps),
        .taps_vld (taps_vld)
    );

    typedef struct packed {
        logic                     v2;
        logic [N_PART*PART_W-1:0] psum;
        logic [DATA_W-1:0]        samp2;
        logic                     v3;
        logic [SUM_W-1:0]         sum;
        logic [DATA_W-1:0]        samp3;
        logic                     v4;
        logic [DATA_W-1:0]        trend;
        logic [RES_W-1:0]         resid;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [N_PART*PART_W-1:0] psum_c;
    logic [SUM_W-1:0]         sum_c;

    // levels 1..CUT_LVL, ahead of the stage-2 registers
    mavg_tree #(.IN_W(DATA_W), .N_IN(DEPTH), .LEVELS(CUT_LVL)) i_tree_lo (
        .operands (taps),
        .sums     (psum_c)
    );

    // remaining levels, ahead of the stage-3 registers
    mavg_tree #(.IN_W(PART_W), .N_IN(N_PART), .LEVELS(WIN_LOG2 - CUT_LVL)) i_tree_hi (
        .operands (pipe_q.psum),
        .sums     (sum_c)
    );

    logic signed [SUM_W-1:0] mean_full;

    always_comb begin
        pipe_d = pipe_q;
        // stage 2
        pipe_d.v2    = taps_vld;
        pipe_d.psum  = psum_c;
        pipe_d.samp2 = taps[TAP_IDX*DATA_W +: DATA_W];
        // stage 3
        pipe_d.v3    = pipe_q.v2;
        pipe_d.sum   = sum_c;
        pipe_d.samp3 = pipe_q.samp2;
        // stage 4
        mean_full    = signed'(pipe_q.sum) >>> WIN_LOG2;
        pipe_d.v4    = pipe_q.v3;
        pipe_d.trend = mean_full[DATA_W-1:0];
        pipe_d.resid = RES_W'(signed'(pipe_q.samp3)) - RES_W'(signed'(mean_full[DATA_W-1:0]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.v4;
    assign out_trend = pipe_q.trend;
    assign out_resid = pipe_q.resid;

endmodule

// File: rtl/mavg_trend_decomp_chk.sv
module mavg_trend_decomp_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_trend,
    input logic [DATA_W:0]   out_resid
);
    localparam int NV_W = $clog2(DEPTH + 1);

    logic [2:0]      cyc_q;
    logic [NV_W-1:0] nval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            nval_q <= '0;
        end else begin
            if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
            if (in_valid && nval_q != NV_W'(DEPTH)) nval_q <= nval_q + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_trend == '0 && out_resid == '0));

    p_fill_gate_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (nval_q >= NV_W'(DEPTH)));

    p_latency_back_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && out_valid) |-> $past(in_valid, 4));

    p_latency_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && $past(in_valid, 4) && $past(nval_q, 4) >= NV_W'(DEPTH - 1)) |-> out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd5 && !$past(in_valid, 4)) |-> (!out_valid && $stable(out_trend) && $stable(out_resid)));

endmodule

bind mavg_trend_decomp mavg_trend_decomp_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_trend (out_trend),
    .out_resid (out_resid)
);

// File: tb/test_mavg_trend_decomp.sv
module test_mavg_trend_decomp;
    import mavg_pkg::*;

    localparam int DW  = 8;
    localparam int WIN = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_sample;

    logic          n_valid, c_valid;
    logic [DW-1:0] n_trend, c_trend;
    logic [DW:0]   n_resid, c_resid;

    mavg_trend_decomp #(.DATA_W(DW), .RES_TAP(RES_NEWEST)) i_mavg_trend_decomp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(n_valid), .out_trend(n_trend), .out_resid(n_resid)
    );

    mavg_trend_decomp #(.DATA_W(DW), .RES_TAP(RES_CENTRE)) i_mavg_trend_decomp_c (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(c_valid), .out_trend(c_trend), .out_resid(c_resid)
    );

    int  total = 0;
    int  bad   = 0;
    int  ecnt  = 0;
    bit  done  = 0;
    int  hist[$];
    bit  ev[8];
    int  et[8], en[8], ec[8];

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the rising edge, check at the next falling edge
    task automatic step(bit v, int x);
        int s;
        int sum;
        int t;
        in_valid  = v;
        in_sample = x[DW-1:0];
        @(posedge clk);
        ecnt++;
        if (v) begin
            hist.push_back(x);
            if (hist.size() > WIN) void'(hist.pop_front());
            if (hist.size() == WIN) begin
                sum = 0;
                foreach (hist[k]) sum += hist[k];
                t = sum >>> 6;
                s = (ecnt + 3) % 8;
                ev[s] = 1'b1;
                et[s] = t;
                en[s] = x - t;
                ec[s] = hist[WIN - 1 - WIN / 2] - t;
            end
        end
        @(negedge clk);
        s = ecnt % 8;
        chk("R2 R5 R7 out_valid newest", int'(n_valid), int'(ev[s]));
        chk("R2 R5 R7 out_valid centre", int'(c_valid), int'(ev[s]));
        if (ev[s]) begin
            chk("R3 R4 trend", int'($signed(n_trend)), et[s]);
            chk("R3 R4 trend centre", int'($signed(c_trend)), et[s]);
            chk("R6 residual newest", int'($signed(n_resid)), en[s]);
            chk("R8 residual centre", int'($signed(c_resid)), ec[s]);
        end
        ev[s] = 1'b0;
    endtask

    function automatic int rnd();
        return int'($urandom_range(255)) - 128;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_sample = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk("R1 valid", int'(n_valid), 0);
        chk("R1 trend", int'(n_trend), 0);
        chk("R1 resid", int'(n_resid), 0);
        chk("R1 valid centre", int'(c_valid), 0);

        // R2: 63 fills produce nothing, the 64th produces the first result
        for (int i = 0; i < 64; i++) step(1'b1, rnd());
        // random continuous stream
        for (int i = 0; i < 200; i++) step(1'b1, rnd());
        // R7: gapped valid pattern
        for (int i = 0; i < 200; i++) step(($urandom_range(1) == 1), rnd());
        // R7: longer idle run, outputs must stay silent
        for (int i = 0; i < 8; i++) step(1'b0, rnd());
        // R3: all most positive, then all most negative
        for (int i = 0; i < 80; i++) step(1'b1, 127);
        for (int i = 0; i < 80; i++) step(1'b1, -128);
        // R4: 63 zeros and a single -1 floors to -1
        for (int i = 0; i < 64; i++) step(1'b1, 0);
        step(1'b1, -1);
        for (int i = 0; i < 3; i++) step(1'b0, 0);
        // alternating extremes with gaps
        for (int i = 0; i < 100; i++) step((i % 3) != 1, (i % 2 == 0) ? 127 : -128);
        // drain
        for (int i = 0; i < 6; i++) step(1'b0, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule